// File: doc/BRIEF.md
# Low-Voltage Programming Entry Detector

This block sits on the target side of a two-wire serial programming link, a clock line and a data line. It decides when the target enters program mode. It samples both lines and an active-low mode-select level into the system clock domain. A data bit is taken on each falling edge of the serial clock. While mode-select is held low, the block compares the most recent 32 bits with a fixed entry key. The bits arrive least significant first.

When a full-length key matches and low-voltage entry is enabled, the block raises a program-mode flag. The flag gates a downstream command interface and parks the general I/O as high-impedance inputs. On entry the block also issues a single-cycle reset pulse. That pulse resets the rest of the target and clears the programming address. A separate digital input stands for the high-voltage entry path and grants program mode whatever the enable bit says. Low-voltage program mode lasts only while mode-select stays low. High-voltage program mode lasts only while its input stays high.

Top module: `lvp_entry_detect`

## Requirements
- R1: After reset, prog_mode_o and entry_rst_o are both 0.
- R2: With lv_en_i=1 and sel_ni low, the key 0x4D434850 sent least significant bit first (bit 0 on the first falling serial clock edge) raises prog_mode_o.
- R3: Each entry into program mode, low- or high-voltage, gives exactly one entry_rst_o pulse of one system clock. The pulse falls in the same cycle prog_mode_o rises.
- R4: Any other 32-bit pattern gives no entry. This includes the key sent most significant bit first and the bitwise-inverted key.
- R5: With lv_en_i=0, the correct key gives no entry.
- R6: While hv_entry_i is 1, prog_mode_o is 1 from the next cycle on, whatever lv_en_i is. High-voltage program mode ends when hv_entry_i returns to 0.
- R7: Low-voltage program mode ends after sel_ni returns high.
- R8: Fewer than 32 key bits since sel_ni went low never give entry. This holds even when the shift window already equals the key, as with the top 28 key bits alone.
- R9: Bits sent before the key do not block entry. The window slides, so a correct key after any prefix is still recognised.
- R10: Raising sel_ni clears the received bits. A key split by a high pulse on sel_ni gives no entry.
- R11: Data is taken at the falling serial clock edge. A data value that is wrong at the rising edge but correct before the fall still counts as correct.
- R12: While in low-voltage program mode, further serial clocks, including another full key, cause no new entry pulse and prog_mode_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pgm_clk_i | input | 1 | Serial programming clock (asynchronous) |
| pgm_dat_i | input | 1 | Serial programming data (asynchronous) |
| sel_ni | input | 1 | Active-low mode-select level (asynchronous) |
| lv_en_i | input | 1 | Low-voltage entry enable configuration bit |
| hv_entry_i | input | 1 | High-voltage entry present, synchronous level |
| prog_mode_o | output | 1 | Program mode active |
| entry_rst_o | output | 1 | One-cycle reset pulse on program-mode entry |

## Verification
The bench builds the block with its default parameters: a 32-bit key of 0x4D434850 and a two-stage input synchroniser. With these values the bit counter saturates at exactly 32. The bench can then reach the case where a 28-bit tail already fills the window with the key value, since the key's low nibble is zero. Serial clock half-periods of four system clocks leave room to change the data inside a high phase. This exercises falling-edge sampling against a late data change.

// File: rtl/lvp_pkg.sv
package lvp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PROG_LV = 2'd1,
    ST_PROG_HV = 2'd2
  } lvp_state_e;

  localparam int unsigned  KEY_W_DEF = 32;
  localparam logic [31:0]  KEY_DEF   = 32'h4D43_4850;
endpackage

// File: rtl/lvp_sync.sv
module lvp_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lvp_fall_det.sv
module lvp_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/lvp_key_shift.sv
module lvp_key_shift #(
  parameter int unsigned      KEY_W = 32,
  parameter logic [KEY_W-1:0] KEY   = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic shift_i,
  input  logic bit_i,
  output logic full_o,
  output logic match_o
);
  localparam int unsigned CNT_W = $clog2(KEY_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(KEY_W);

  logic [KEY_W-1:0] sr_q;
  logic [CNT_W-1:0] cnt_q;

  // LSB-first: newest bit enters at the top, first bit ends at bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q <= {bit_i, sr_q[KEY_W-1:1]};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign full_o  = (cnt_q == CNT_MAX);
  assign match_o = full_o && (sr_q == KEY);
endmodule

// File: rtl/lvp_entry_detect.sv
module lvp_entry_detect
  import lvp_pkg::*;
#(
  parameter int unsigned      KEY_W       = KEY_W_DEF,
  parameter logic [KEY_W-1:0] KEY         = KEY_W'(KEY_DEF),
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pgm_clk_i,
  input  logic pgm_dat_i,
  input  logic sel_ni,
  input  logic lv_en_i,
  input  logic hv_entry_i,
  output logic prog_mode_o,
  output logic entry_rst_o
);
  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] raw, synced;
  logic pgm_clk_s, pgm_dat_s, sel_s;
  logic clk_fall, shift_en, key_full, key_match;
  lvp_state_e state_q, state_d;
  logic entry_rst_q;

  assign raw = {sel_ni, pgm_dat_i, pgm_clk_i};

  lvp_sync #(
    .W      (NSYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign pgm_clk_s = synced[0];
  assign pgm_dat_s = synced[1];
  assign sel_s     = synced[2];

  lvp_fall_det u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pgm_clk_s),
    .fall_o(clk_fall)
  );

  // key bits are only collected while idle with the select pin low
  assign shift_en = clk_fall && !sel_s && (state_q == ST_IDLE);

  lvp_key_shift #(
    .KEY_W(KEY_W),
    .KEY  (KEY)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sel_s),
    .shift_i(shift_en),
    .bit_i  (pgm_dat_s),
    .full_o (key_full),
    .match_o(key_match)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (hv_entry_i)                            state_d = ST_PROG_HV;
        else if (key_match && lv_en_i && !sel_s)   state_d = ST_PROG_LV;
      end
      ST_PROG_LV: if (sel_s)       state_d = ST_IDLE;
      ST_PROG_HV: if (!hv_entry_i) state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      entry_rst_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      entry_rst_q <= (state_q == ST_IDLE) && (state_d != ST_IDLE);
    end
  end

  assign prog_mode_o = (state_q != ST_IDLE);
  assign entry_rst_o = entry_rst_q;
endmodule

// File: rtl/lvp_entry_detect_chk.sv
module lvp_entry_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hv_entry_i,
  input logic lv_en_i,
  input logic prog_mode_o,
  input logic entry_rst_o,
  input logic key_full_i
);
  a_r3_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_rst_o |=> !entry_rst_o);

  a_r3_pulse_in_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_rst_o |-> prog_mode_o);

  a_r3_rise_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_mode_o) |-> entry_rst_o);

  a_r6_hv_grants: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_entry_i |=> prog_mode_o);

  a_r5_lv_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(prog_mode_o) && !$past(hv_entry_i)) |-> $past(lv_en_i));

  a_r8_full_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(prog_mode_o) && !$past(hv_entry_i)) |-> $past(key_full_i));
endmodule

bind lvp_entry_detect lvp_entry_detect_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hv_entry_i (hv_entry_i),
  .lv_en_i    (lv_en_i),
  .prog_mode_o(prog_mode_o),
  .entry_rst_o(entry_rst_o),
  .key_full_i (key_full)
);

// File: tb/lvp_entry_detect_tb.sv
module lvp_entry_detect_tb;
  localparam logic [31:0] KEY = 32'h4D43_4850;
  // vector: {kind[3:0], lv_en, expect_entry}
  localparam int NVEC = 8;
  localparam logic [5:0] VEC [NVEC] = '{
    {4'd0, 1'b1, 1'b1},  // R2 correct key
    {4'd1, 1'b1, 1'b0},  // R4 msb first
    {4'd2, 1'b1, 1'b0},  // R4 inverted
    {4'd0, 1'b0, 1'b0},  // R5 enable off
    {4'd3, 1'b1, 1'b0},  // R8 28-bit tail
    {4'd4, 1'b1, 1'b1},  // R9 prefix then key
    {4'd5, 1'b1, 1'b0},  // R10 split by sel pulse
    {4'd6, 1'b1, 1'b1}   // R11 late data
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pgm_clk = 1'b0, pgm_dat = 1'b0, sel_n = 1'b1, lv_en = 1'b1, hv = 1'b0;
  logic prog_mode, entry_rst;
  int checks = 0, fails = 0, pulses = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lvp_entry_detect u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pgm_clk_i  (pgm_clk),
    .pgm_dat_i  (pgm_dat),
    .sel_ni     (sel_n),
    .lv_en_i    (lv_en),
    .hv_entry_i (hv),
    .prog_mode_o(prog_mode),
    .entry_rst_o(entry_rst)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && entry_rst) pulses <= pulses + 1;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input bit late);
    @(negedge clk);
    pgm_clk = 1'b1;
    pgm_dat = late ? ~b : b;
    wait_clk(2);
    pgm_dat = b;
    wait_clk(2);
    pgm_clk = 1'b0;
    wait_clk(4);
  endtask

  task automatic send_key(input logic [31:0] k, input int lo, input int hi, input bit late);
    for (int i = lo; i <= hi; i++) send_bit(k[i], late);
  endtask

  task automatic run_vec(input logic [3:0] kind);
    case (kind)
      4'd0: send_key(KEY, 0, 31, 1'b0);
      4'd1: for (int i = 0; i < 32; i++) send_bit(KEY[31-i], 1'b0);
      4'd2: send_key(~KEY, 0, 31, 1'b0);
      4'd3: send_key(KEY, 4, 31, 1'b0);
      4'd4: begin
        for (int i = 0; i < 9; i++) send_bit(1'b1, 1'b0);
        send_key(KEY, 0, 31, 1'b0);
      end
      4'd5: begin
        send_key(KEY, 0, 15, 1'b0);
        sel_n = 1'b1; wait_clk(8);
        sel_n = 1'b0; wait_clk(8);
        send_key(KEY, 16, 31, 1'b0);
      end
      default: send_key(KEY, 0, 31, 1'b1);
    endcase
  endtask

  initial begin
    int p0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    chk("R1 prog_mode after reset", prog_mode, 0);
    chk("R1 entry_rst after reset", entry_rst, 0);

    for (int v = 0; v < NVEC; v++) begin
      lv_en = VEC[v][1];
      sel_n = 1'b0;
      wait_clk(6);
      p0 = pulses;
      run_vec(VEC[v][5:2]);
      wait_clk(8);
      chk($sformatf("R2/R4/R5/R8-R11 vec%0d prog_mode", v), prog_mode, VEC[v][0]);
      chk($sformatf("R3 vec%0d pulse count", v), pulses - p0, VEC[v][0]);
      sel_n = 1'b1;
      wait_clk(8);
      chk($sformatf("R7 vec%0d exit on sel release", v), prog_mode, 0);
    end

    // R12: key again plus one more clock while in program mode
    lv_en = 1'b1; sel_n = 1'b0; wait_clk(6);
    send_key(KEY, 0, 31, 1'b0);
    wait_clk(8);
    p0 = pulses;
    send_key(KEY, 0, 31, 1'b0);
    send_bit(1'b0, 1'b0);
    wait_clk(8);
    chk("R12 stays in program mode", prog_mode, 1);
    chk("R12 no second pulse", pulses - p0, 0);
    sel_n = 1'b1; wait_clk(8);
    chk("R7 exit after R12 run", prog_mode, 0);

    // R6: high-voltage entry with lv disabled, select high
    lv_en = 1'b0; p0 = pulses;
    hv = 1'b1;
    wait_clk(2);
    chk("R6 hv grants program mode", prog_mode, 1);
    chk("R3 hv entry single pulse", pulses - p0, 1);
    wait_clk(10);
    chk("R6 hv mode held", prog_mode, 1);
    hv = 1'b0;
    wait_clk(2);
    chk("R6 hv exit", prog_mode, 0);
    chk("R3 hv total pulses", pulses - p0, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule